// File: doc/BRIEF.md
# Double-Rate Half-Word Memory Bridge

This block connects a requester that issues 32-bit memory accesses to an external data path that is only 16 bits wide. The memory side runs on a clock at exactly twice the system clock frequency, with its rising edges aligned to the system clock. Each system cycle is therefore split into two fast periods. The bridge moves one half-word in each of them, so the requester can issue a full 32-bit read or write every system cycle. A plain width converter would need two system cycles per word.

Writes are split into a low and a high half. Each half carries its own two-bit byte mask, taken from the requester's four byte enables. Reads are issued as two half-word reads, and the two returned halves are joined back into one word. The word goes back to the system side after a fixed number of system cycles. A half-select flag is derived from the system clock and tells the fast-side logic which half of the system cycle it is in. The external memory is treated as a plain 16-bit memory that returns read data a fixed number of fast cycles (`RD_LAT`) after it samples a read command.

Top module: `halfword_mem_bridge`

## Requirements
- R1: A request presented at any system clock edge is accepted without stall. `mem_en` is high in both fast periods of the following system cycle, and low in both when no request was sampled, so back-to-back requests keep one word per system cycle.
- R2: In the first fast period after the edge that samples a request, the bridge drives `mem_addr = {req_addr, 1'b0}`, `mem_wdata = req_wdata[15:0]`, `mem_mask = req_be[1:0]` and `mem_we = req_write`.
- R3: In the second fast period, the one ending at the next system edge, the bridge drives `mem_addr = {req_addr, 1'b1}`, `mem_wdata = req_wdata[31:16]` and `mem_mask = req_be[3:2]`.
- R4: `mem_mask` bit 0 selects bits 7:0 and bit 1 selects bits 15:8 of the half-word. A byte whose enable is 0 keeps its old content, including when all four enables are 0.
- R5: A read sampled at system edge n raises `rsp_valid` for exactly one system cycle, starting right after edge n + 2 + RD_LAT/2 (integer division), with `rsp_rdata = {high half, low half}`.
- R6: Writes produce no response. `rsp_valid` is low in every cycle that does not carry a read result.
- R7: While `rst_n` is low at a system edge, `mem_en` and `rsp_valid` go low after that edge and the half flag selects the low half. A read that is in flight when reset is asserted never produces a response.
- R8: A read issued in the system cycle right after a write to the same word returns the merged data of that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| clk_mem | input | 1 | Memory-side clock, twice the system rate, rising edges aligned |
| rst_n | input | 1 | Synchronous active-low reset for both clock domains |
| req_valid | input | 1 | Request present this system cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit i for byte i |
| rsp_valid | output | 1 | Read result valid, one system cycle per read |
| rsp_rdata | output | DATA_W | Read result |
| mem_en | output | 1 | Half-word command valid this fast period |
| mem_we | output | 1 | Half-word command is a write |
| mem_addr | output | ADDR_W+1 | Half-word address: word address with the half index as LSB |
| mem_wdata | output | DATA_W/2 | Half-word write data |
| mem_mask | output | DATA_W/16 | Per-byte write mask of this half |
| mem_rdata | input | DATA_W/2 | Half-word read data from memory |

## Verification
The half-word commands for a request sampled at system edge T are due in the fast periods [T, T+2 ns) and [T+2 ns, T+4 ns). The bench samples them on the falling fast edges in the middle of each period, where nothing is changing. Read results are due two system edges after the sampling edge for the single-cycle memory model. The bench shifts its own expected-read record through a pipeline one stage longer than that latency and compares it with `rsp_valid`/`rsp_rdata` on every falling system edge. That comparison covers both the presence and the absence of a response. Byte-mask behaviour is observed by reading each word back in the cycle right after each of the 16 byte-enable patterns is written to it, with expected data built from a shadow copy in the bench.

// File: rtl/hwb_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the double-rate half-word bridge.
package hwb_pkg;

    // Tag riding alongside a half-word read through the memory latency.
    typedef struct packed {
        logic rd;   // a read command was issued
        logic hi;   // it targeted the high half
    } hwb_tag_t;

    // System-cycle latency from request sampling edge to rsp_valid.
    function automatic int unsigned hwb_rsp_lat(input int unsigned rd_lat);
        return 2 + rd_lat / 2;
    endfunction

endpackage

// File: rtl/hwb_req_stage.sv
`timescale 1ns/1ps
// Request register on the system clock.
// Holds one accepted request for one full system cycle so both fast
// periods of that cycle see stable fields. Assumes no back-pressure.
module hwb_req_stage #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [BE_W-1:0]   in_be,
    output logic              q_valid,
    output logic              q_write,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [BE_W-1:0]   q_be
);

    // Capture the request presented at this system edge.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_write <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_be    <= '0;
        end else begin
            q_valid <= in_valid;
            q_write <= in_write;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_be    <= in_be;
        end
    end

endmodule

// File: rtl/hwb_phase_gen.sv
`timescale 1ns/1ps
// Half-select flag for the fast clock.
// A register toggles on every system edge. The fast domain keeps a copy of
// it, delayed by one fast edge. The two agree only in the second fast period
// of a system cycle, which marks the high half. Assumes clk_mem is exactly
// 2x clk_sys with coincident rising edges. The flag is forced low in reset.
module hwb_phase_gen (
    input  logic clk_sys,
    input  logic clk_mem,
    input  logic rst_n,
    output logic phase_hi
);

    logic sys_tog;
    logic tog_seen;

    // Toggle once per system cycle.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) sys_tog <= 1'b0;
        else        sys_tog <= ~sys_tog;
    end

    // Follow the toggle one fast edge late.
    always_ff @(posedge clk_mem) begin
        if (!rst_n) tog_seen <= 1'b0;
        else        tog_seen <= sys_tog;
    end

    assign phase_hi = rst_n & (sys_tog == tog_seen);

endmodule

// File: rtl/hwb_half_split.sv
`timescale 1ns/1ps
// Half-word command former.
// Uses the half flag to pick the data half and the byte-mask half of the
// held request, and appends the flag as the half-word address LSB.
// Purely combinational.
module hwb_half_split #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    localparam int HALF_W  = DATA_W / 2,
    localparam int BE_W    = DATA_W / 8,
    localparam int MASK_W  = BE_W / 2
) (
    input  logic              phase_hi,
    input  logic              q_valid,
    input  logic              q_write,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [DATA_W-1:0] q_wdata,
    input  logic [BE_W-1:0]   q_be,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [HALF_W-1:0] mem_wdata,
    output logic [MASK_W-1:0] mem_mask
);

    logic [1:0][HALF_W-1:0] data_halves;
    logic [1:0][MASK_W-1:0] mask_halves;

    assign data_halves = q_wdata;
    assign mask_halves = q_be;

    // Select the half for the current fast period.
    always_comb begin
        mem_en    = q_valid;
        mem_we    = q_valid & q_write;
        mem_addr  = {q_addr, phase_hi};
        mem_wdata = data_halves[phase_hi];
        mem_mask  = mask_halves[phase_hi];
    end

endmodule

// File: rtl/hwb_read_assembler.sv
`timescale 1ns/1ps
// Read-word builder on the fast clock.
// Delays each command's tag by the memory's read latency, stores the
// returning low half, and joins it with the high half into a word.
// The word and its valid flag change only on high-half return edges,
// so they stay stable across one system edge. Assumes RD_LAT >= 1.
module hwb_read_assembler
    import hwb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RD_LAT  = 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk_mem,
    input  logic              rst_n,
    input  hwb_tag_t          tag_in,
    input  logic [HALF_W-1:0] mem_rdata,
    output logic              word_valid,
    output logic [DATA_W-1:0] word
);

    hwb_tag_t [RD_LAT-1:0] tag_pipe;
    hwb_tag_t              head;
    logic [HALF_W-1:0]     lo_buf;

    // Tag delay line matching the memory read latency.
    generate
        if (RD_LAT == 1) begin : g_single
            always_ff @(posedge clk_mem) begin
                if (!rst_n) tag_pipe <= '0;
                else        tag_pipe <= tag_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk_mem) begin
                if (!rst_n) tag_pipe <= '0;
                else        tag_pipe <= {tag_pipe[RD_LAT-2:0], tag_in};
            end
        end
    endgenerate

    assign head = tag_pipe[RD_LAT-1];

    // Capture the halves as they return and publish the joined word.
    always_ff @(posedge clk_mem) begin
        if (!rst_n) begin
            lo_buf     <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else if (head.hi) begin
            word_valid <= head.rd;
            if (head.rd) word <= {mem_rdata, lo_buf};
        end else if (head.rd) begin
            lo_buf <= mem_rdata;
        end
    end

endmodule

// File: rtl/halfword_mem_bridge.sv
`timescale 1ns/1ps
// Double-rate half-word memory bridge (top).
// Accepts one DATA_W access per system cycle and issues it as two half-word
// commands on the 2x memory clock: low half first, then high half. Read
// results come back RSP_LAT system edges after the request is sampled.
// Assumes the memory returns read data RD_LAT fast cycles after sampling.
module halfword_mem_bridge
    import hwb_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int RD_LAT   = 1,
    localparam int HALF_W  = DATA_W / 2,
    localparam int BE_W    = DATA_W / 8,
    localparam int MASK_W  = BE_W / 2
) (
    input  logic              clk_sys,
    input  logic              clk_mem,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [HALF_W-1:0] mem_wdata,
    output logic [MASK_W-1:0] mem_mask,
    input  logic [HALF_W-1:0] mem_rdata
);

    logic              q_valid;
    logic              q_write;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [BE_W-1:0]   q_be;
    logic              phase_hi;
    hwb_tag_t          cmd_tag;
    logic              word_valid;
    logic [DATA_W-1:0] word;

    hwb_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .in_valid(req_valid),
        .in_write(req_write),
        .in_addr (req_addr),
        .in_wdata(req_wdata),
        .in_be   (req_be),
        .q_valid (q_valid),
        .q_write (q_write),
        .q_addr  (q_addr),
        .q_wdata (q_wdata),
        .q_be    (q_be)
    );

    hwb_phase_gen u_phase (
        .clk_sys (clk_sys),
        .clk_mem (clk_mem),
        .rst_n   (rst_n),
        .phase_hi(phase_hi)
    );

    hwb_half_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_split (
        .phase_hi (phase_hi),
        .q_valid  (q_valid),
        .q_write  (q_write),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .q_be     (q_be),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_mask (mem_mask)
    );

    assign cmd_tag.rd = mem_en & ~mem_we;
    assign cmd_tag.hi = phase_hi;

    hwb_read_assembler #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_asm (
        .clk_mem   (clk_mem),
        .rst_n     (rst_n),
        .tag_in    (cmd_tag),
        .mem_rdata (mem_rdata),
        .word_valid(word_valid),
        .word      (word)
    );

    // Bring the joined word back onto the system clock.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= word_valid;
            rsp_rdata <= word;
        end
    end

endmodule

// File: rtl/hwb_checker.sv
`timescale 1ns/1ps
// Property checker for halfword_mem_bridge, attached with bind.
// Keeps its own copy of the last sampled request and a read-flag delay line
// of the documented response latency, and compares the ports against them.
module hwb_checker
    import hwb_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int RD_LAT   = 1,
    localparam int HALF_W  = DATA_W / 2,
    localparam int BE_W    = DATA_W / 8,
    localparam int MASK_W  = BE_W / 2,
    localparam int RSP_LAT = hwb_rsp_lat(RD_LAT)
) (
    input logic              clk_sys,
    input logic              clk_mem,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [BE_W-1:0]   req_be,
    input logic              rsp_valid,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W:0]   mem_addr,
    input logic [HALF_W-1:0] mem_wdata,
    input logic [MASK_W-1:0] mem_mask
);

    logic              exp_valid;
    logic              exp_write;
    logic [ADDR_W-1:0] exp_addr;
    logic [DATA_W-1:0] exp_wdata;
    logic [BE_W-1:0]   exp_be;
    logic [RSP_LAT:0]  rd_line;

    // Remember the request sampled at each system edge.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_write <= 1'b0;
            exp_addr  <= '0;
            exp_wdata <= '0;
            exp_be    <= '0;
            rd_line   <= '0;
        end else begin
            exp_valid <= req_valid;
            exp_write <= req_write;
            exp_addr  <= req_addr;
            exp_wdata <= req_wdata;
            exp_be    <= req_be;
            rd_line   <= {rd_line[RSP_LAT-1:0], req_valid & ~req_write};
        end
    end

    // R1: both fast periods carry a command exactly when a request was taken.
    a_r1_cmd_slot_lo: assert property (@(negedge clk_sys) disable iff (!rst_n)
        mem_en == exp_valid);
    a_r1_cmd_slot_hi: assert property (@(posedge clk_sys) disable iff (!rst_n)
        mem_en == exp_valid);

    // R2: first fast period carries the low half.
    a_r2_low_half: assert property (@(negedge clk_sys) disable iff (!rst_n)
        exp_valid |-> (mem_addr == {exp_addr, 1'b0}) && (mem_we == exp_write)
                   && (mem_wdata == exp_wdata[HALF_W-1:0])
                   && (mem_mask == exp_be[MASK_W-1:0]));

    // R3: second fast period carries the high half.
    a_r3_high_half: assert property (@(posedge clk_sys) disable iff (!rst_n)
        exp_valid |-> (mem_addr == {exp_addr, 1'b1}) && (mem_we == exp_write)
                   && (mem_wdata == exp_wdata[DATA_W-1:HALF_W])
                   && (mem_mask == exp_be[BE_W-1:MASK_W]));

    // R5 and R6: a response appears exactly RSP_LAT edges after each read only.
    a_r5_rsp_timing: assert property (@(posedge clk_sys) disable iff (!rst_n)
        rsp_valid == rd_line[RSP_LAT]);

    // R7: reset silences the command and response outputs.
    a_r7_reset_quiet: assert property (@(posedge clk_sys)
        !rst_n |=> (!mem_en && !rsp_valid));

    // R4 and R8 concern stored memory content; the bench checks them.

endmodule

bind halfword_mem_bridge hwb_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RD_LAT(RD_LAT)
) u_hwb_checker (
    .clk_sys  (clk_sys),
    .clk_mem  (clk_mem),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .rsp_valid(rsp_valid),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_mask (mem_mask)
);

// File: tb/halfword_mem_bridge_test.sv
`timescale 1ns/1ps
module halfword_mem_bridge_test;
    import hwb_pkg::*;

    localparam int AW      = 4;
    localparam int WORDS   = 1 << AW;
    localparam int RDL     = 1;
    localparam int RSP_LAT = hwb_rsp_lat(RDL);

    logic        clk_sys = 1'b0;
    logic        clk_mem = 1'b0;
    logic        rst_n   = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_en;
    logic        mem_we;
    logic [AW:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_mask;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    logic        run_mon = 1'b0;
    logic        exp_v_in = 1'b0;
    logic [31:0] exp_d_in = '0;
    logic        pv [RSP_LAT+1];
    logic [31:0] pd [RSP_LAT+1];
    logic [31:0] shadow [WORDS];
    logic [15:0] hmem [2*WORDS];

    halfword_mem_bridge #(.ADDR_W(AW), .DATA_W(32), .RD_LAT(RDL)) uut (
        .clk_sys(clk_sys), .clk_mem(clk_mem), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_mask(mem_mask), .mem_rdata(mem_rdata)
    );

    // 250 MHz system clock, 500 MHz memory clock, rising edges aligned.
    initial begin
        forever begin
            #1 clk_sys = 1'b1; clk_mem = 1'b1;
            #1 clk_mem = 1'b0;
            #1 clk_sys = 1'b0; clk_mem = 1'b1;
            #1 clk_mem = 1'b0;
        end
    end

    // 16-bit memory model, one fast cycle read latency.
    always @(posedge clk_mem) begin
        if (mem_en && mem_we) begin
            if (mem_mask[0]) hmem[mem_addr][7:0]  <= mem_wdata[7:0];
            if (mem_mask[1]) hmem[mem_addr][15:8] <= mem_wdata[15:8];
        end else if (mem_en) begin
            mem_rdata <= hmem[mem_addr];
        end
    end

    // Expected-response delay line, one stage per system edge.
    always @(posedge clk_sys) begin
        if (!rst_n) begin
            for (int i = 0; i <= RSP_LAT; i++) begin pv[i] <= 1'b0; pd[i] <= '0; end
        end else begin
            pv[0] <= exp_v_in; pd[0] <= exp_d_in;
            for (int i = 1; i <= RSP_LAT; i++) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
        end
    end

    // Response monitor (R5, R6 and the phase's requirement).
    always @(negedge clk_sys) begin
        if (rst_n && run_mon) begin
            checks++;
            if (rsp_valid !== pv[RSP_LAT]) begin
                errors++;
                $display("FAIL %s rsp_valid=%0b expected %0b", pv[RSP_LAT] ? "R5" : "R6",
                         rsp_valid, pv[RSP_LAT]);
            end else if (rsp_valid && rsp_rdata !== pd[RSP_LAT]) begin
                errors++;
                $display("FAIL %s rsp_rdata=%h expected %h", cur_req, rsp_rdata, pd[RSP_LAT]);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request for one system cycle; returns 1 ns after the sampling edge.
    task automatic issue(input logic wr, input int a, input logic [31:0] d, input logic [3:0] be);
        req_valid = 1'b1; req_write = wr; req_addr = a[AW-1:0]; req_wdata = d; req_be = be;
        if (wr) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
            exp_v_in = 1'b0;
        end else begin
            exp_v_in = 1'b1;
            exp_d_in = shadow[a];
        end
        @(posedge clk_sys); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            req_valid = 1'b0; exp_v_in = 1'b0;
            @(posedge clk_sys); #1;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        repeat (3) @(posedge clk_sys);
        #1;
        // R7: quiet outputs during reset
        chk("R7", {31'b0, rsp_valid}, 32'd0);
        chk("R7", {31'b0, mem_en}, 32'd0);
        rst_n = 1'b1;
        run_mon = 1'b1;
        idle(2);

        // R2/R3: half-word fields of one write
        cur_req = "R2";
        issue(1'b1, 5, 32'hA1B2_C3D4, 4'b1101);
        chk("R2", {31'b0, mem_en}, 32'd1);
        chk("R2", {31'b0, mem_we}, 32'd1);
        chk("R2", {27'b0, mem_addr}, 32'd10);
        chk("R2", {16'b0, mem_wdata}, 32'h0000_C3D4);
        chk("R2", {30'b0, mem_mask}, 32'd1);
        #2;
        chk("R3", {31'b0, mem_en}, 32'd1);
        chk("R3", {27'b0, mem_addr}, 32'd11);
        chk("R3", {16'b0, mem_wdata}, 32'h0000_A1B2);
        chk("R3", {30'b0, mem_mask}, 32'd3);
        #2;
        idle(1);
        // R1: no command in the period after an idle cycle
        #2 chk("R1", {31'b0, mem_en}, 32'd0);
        #2;

        // R1/R5: back-to-back full-word writes, then back-to-back reads
        cur_req = "R1";
        for (int a = 0; a < WORDS; a++) issue(1'b1, a, $urandom, 4'hF);
        cur_req = "R5";
        for (int a = 0; a < WORDS; a++) issue(1'b0, a, 32'h0, 4'h0);
        idle(RSP_LAT + 1);

        // R4/R8: every byte-enable pattern on every word, read right after
        cur_req = "R4";
        for (int a = 0; a < WORDS; a++)
            for (int be = 0; be < 16; be++) begin
                issue(1'b1, a, $urandom, be[3:0]);
                issue(1'b0, a, 32'h0, 4'h0);
            end
        idle(RSP_LAT + 1);

        // R8: mixed random traffic, reads ordered behind writes
        cur_req = "R8";
        for (int i = 0; i < 300; i++) begin
            int a;
            a = $urandom_range(WORDS - 1);
            case ($urandom_range(3))
                0:       idle(1);
                1:       issue(1'b1, a, $urandom, 4'($urandom));
                default: issue(1'b0, a, 32'h0, 4'h0);
            endcase
        end
        idle(RSP_LAT + 1);

        // R7: reset with reads in flight must drop their responses
        cur_req = "R7";
        issue(1'b0, 1, 32'h0, 4'h0);
        issue(1'b0, 2, 32'h0, 4'h0);
        rst_n = 1'b0; req_valid = 1'b0; exp_v_in = 1'b0;
        @(posedge clk_sys); #1;
        chk("R7", {31'b0, rsp_valid}, 32'd0);
        chk("R7", {31'b0, mem_en}, 32'd0);
        @(posedge clk_sys); #1;
        chk("R7", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        idle(RSP_LAT + 3);
        cur_req = "R5";
        issue(1'b0, 3, 32'h0, 4'h0);
        idle(RSP_LAT + 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule